// File: doc/BRIEF.md
# Register-Tracked Conditional Branch Unit

This unit executes the conditional branch of a random-program virtual machine. The branch first builds a 64-bit addend from a 32-bit immediate and a bit position `b`. It adds that addend to the destination integer register. It then looks at a window of `JUMP_BITS` bits of the sum, starting at bit `b`. If every bit in that window is zero, the branch is taken.

The jump target is not encoded in the instruction. The unit keeps a small table with one entry per integer register. Each entry records the index of the last instruction that wrote that register, or marks the register as untouched. The target is the instruction after the recorded writer.

Other instructions report their register writes through a notify port. An iteration-start strobe marks every register as untouched. When a branch executes, it becomes the most recent writer of every register.

Top module: `jtu_branch_unit`

## Requirements
- R1: The addend is the immediate sign-extended to 64 bits, then bit `b` is set to 1. When `b` is at least 1, bit `b-1` is also cleared to 0.
- R2: One cycle after `br_valid_i`, `res_valid_o` pulses high for one cycle and `res_val_o` holds the register value plus the addend, modulo 2^64.
- R3: `res_taken_o` is 1 exactly when bits `b` through `b+JUMP_BITS-1` of `res_val_o` are all zero (bit 0 is the LSB).
- R4: For a register with a recorded writer at index k, `res_target_o` is k+1 modulo 2^IDX_W. It is reported whether or not the branch is taken.
- R5: `iter_start_i` marks every register untouched. A branch in the same cycle already sees the cleared table.
- R6: A branch on an untouched register reports target 0.
- R7: After a branch at index k executes, every register records k as its last writer.
- R8: A write notify records `wr_idx_i` for register `wr_reg_i`. A branch in the same cycle looks up the table state from before that write, and its own update overrides the write.
- R9: A `br_pos_i` value above 64-JUMP_BITS is treated as 64-JUMP_BITS. With `b` = 0, only bit 0 of the addend is forced (to 1).
- R10: After reset, all outputs are zero and every register is untouched. While no branch executes, `res_val_o`, `res_taken_o` and `res_target_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iter_start_i | input | 1 | Marks every register untouched |
| wr_valid_i | input | 1 | Another instruction wrote an integer register |
| wr_reg_i | input | REG_W | Register written |
| wr_idx_i | input | IDX_W | Index of the writing instruction |
| br_valid_i | input | 1 | A branch executes this cycle |
| br_idx_i | input | IDX_W | Index of the branch instruction |
| br_reg_i | input | REG_W | Destination register of the branch |
| br_val_i | input | 64 | Current value of the destination register |
| br_imm_i | input | 32 | Branch immediate |
| br_pos_i | input | 6 | Bit position b of the tested window |
| res_valid_o | output | 1 | Result strobe, one cycle after the branch |
| res_val_o | output | 64 | Updated register value |
| res_taken_o | output | 1 | Branch taken |
| res_target_o | output | IDX_W | Jump target index |

## Verification
The tracking table is visible only through `res_target_o`. A wrong entry, a missed clear, or a dropped write notify therefore stays hidden until the next branch that names the affected register, and then shows as a wrong target one cycle after that branch. Errors in the addend or in the window test show up at once in `res_val_o` or `res_taken_o` on the same result strobe.

For this reason, the reference model is compared on every clock. The stimulus places branches right after writes, after clears and after other branches, so that every kind of table corruption is driven out to the ports.

// File: rtl/jtu_pkg.sv
package jtu_pkg;
  localparam int XLEN  = 64;
  localparam int IMM_W = 32;
  localparam int POS_W = 6;
  typedef logic [XLEN-1:0] word_t;
endpackage

// File: rtl/jtu_cimm.sv
module jtu_cimm
  import jtu_pkg::*;
#(
  parameter int JUMP_BITS = 8
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] pos_o,
  output word_t            cimm_o
);
  localparam int MAX_POS = XLEN - JUMP_BITS;

  always_comb begin
    // keep the tested window inside the word
    pos_o  = (int'(pos_i) > MAX_POS) ? POS_W'(MAX_POS) : pos_i;
    cimm_o = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    cimm_o[pos_o] = 1'b1;
    if (pos_o != '0) cimm_o[pos_o - POS_W'(1)] = 1'b0;
  end
endmodule

// File: rtl/jtu_cond.sv
module jtu_cond
  import jtu_pkg::*;
#(
  parameter int JUMP_BITS = 8
) (
  input  word_t            val_i,
  input  word_t            cimm_i,
  input  logic [POS_W-1:0] pos_i,
  output word_t            sum_o,
  output logic             taken_o
);
  word_t window;

  always_comb begin
    sum_o   = val_i + cimm_i;
    window  = sum_o >> pos_i;
    taken_o = ~|window[JUMP_BITS-1:0];
  end
endmodule

// File: rtl/jtu_track.sv
module jtu_track #(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 8,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_valid_i,
  input  logic [REG_W-1:0] wr_reg_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             br_valid_i,
  input  logic [IDX_W-1:0] br_idx_i,
  input  logic [REG_W-1:0] rd_reg_i,
  output logic [IDX_W-1:0] rd_target_o
);
  logic [NUM_REGS-1:0] seen;
  logic [IDX_W-1:0]    last_idx [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    logic             seen_q;
    logic [IDX_W-1:0] idx_q;

    // priority: branch > write notify > clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seen_q <= 1'b0;
        idx_q  <= '0;
      end else if (br_valid_i) begin
        seen_q <= 1'b1;
        idx_q  <= br_idx_i;
      end else if (wr_valid_i && wr_reg_i == REG_W'(g)) begin
        seen_q <= 1'b1;
        idx_q  <= wr_idx_i;
      end else if (clr_i) begin
        seen_q <= 1'b0;
      end
    end

    assign seen[g]     = seen_q;
    assign last_idx[g] = idx_q;
  end

  // clear is visible to a branch in the same cycle
  always_comb begin
    if (!clr_i && seen[rd_reg_i]) rd_target_o = last_idx[rd_reg_i] + IDX_W'(1);
    else                          rd_target_o = '0;
  end
endmodule

// File: rtl/jtu_branch_unit.sv
module jtu_branch_unit
  import jtu_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int IDX_W     = 8,
  parameter int JUMP_BITS = 8,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iter_start_i,
  input  logic             wr_valid_i,
  input  logic [REG_W-1:0] wr_reg_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             br_valid_i,
  input  logic [IDX_W-1:0] br_idx_i,
  input  logic [REG_W-1:0] br_reg_i,
  input  logic [63:0]      br_val_i,
  input  logic [31:0]      br_imm_i,
  input  logic [5:0]       br_pos_i,
  output logic             res_valid_o,
  output logic [63:0]      res_val_o,
  output logic             res_taken_o,
  output logic [IDX_W-1:0] res_target_o
);
  logic [POS_W-1:0] pos_eff;
  word_t            cimm, sum;
  logic             taken;
  logic [IDX_W-1:0] target;

  jtu_cimm #(.JUMP_BITS(JUMP_BITS)) u_cimm (
    .imm_i  (br_imm_i),
    .pos_i  (br_pos_i),
    .pos_o  (pos_eff),
    .cimm_o (cimm)
  );

  jtu_cond #(.JUMP_BITS(JUMP_BITS)) u_cond (
    .val_i   (br_val_i),
    .cimm_i  (cimm),
    .pos_i   (pos_eff),
    .sum_o   (sum),
    .taken_o (taken)
  );

  jtu_track #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (iter_start_i),
    .wr_valid_i  (wr_valid_i),
    .wr_reg_i    (wr_reg_i),
    .wr_idx_i    (wr_idx_i),
    .br_valid_i  (br_valid_i),
    .br_idx_i    (br_idx_i),
    .rd_reg_i    (br_reg_i),
    .rd_target_o (target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_val_o    <= '0;
      res_taken_o  <= 1'b0;
      res_target_o <= '0;
    end else begin
      res_valid_o <= br_valid_i;
      if (br_valid_i) begin
        res_val_o    <= sum;
        res_taken_o  <= taken;
        res_target_o <= target;
      end
    end
  end
endmodule

// File: rtl/jtu_chk.sv
module jtu_chk #(
  parameter int NUM_REGS  = 8,
  parameter int IDX_W     = 8,
  parameter int JUMP_BITS = 8,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iter_start_i,
  input logic             br_valid_i,
  input logic [IDX_W-1:0] br_idx_i,
  input logic [5:0]       br_pos_i,
  input logic             res_valid_o,
  input logic [63:0]      res_val_o,
  input logic             res_taken_o,
  input logic [IDX_W-1:0] res_target_o
);
  localparam int MAX_POS = 64 - JUMP_BITS;
  localparam logic [63:0] WIN_MASK = (64'(1) << JUMP_BITS) - 64'(1);

  logic             prev_br;
  logic [IDX_W-1:0] prev_idx;
  logic [5:0]       pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_br  <= 1'b0;
      prev_idx <= '0;
      pos_q    <= '0;
    end else begin
      prev_br <= br_valid_i;
      if (br_valid_i) begin
        prev_idx <= br_idx_i;
        pos_q    <= (int'(br_pos_i) > MAX_POS) ? 6'(MAX_POS) : br_pos_i;
      end
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> res_valid_o == $past(br_valid_i));

  // R3
  taken_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_taken_o == (((res_val_o >> pos_q) & WIN_MASK) == 64'd0));

  // R5
  clear_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i && iter_start_i |=> res_target_o == '0);

  // R7
  chain_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i && !iter_start_i && prev_br |=> res_target_o == $past(prev_idx) + IDX_W'(1));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> $stable(res_val_o) && $stable(res_taken_o) && $stable(res_target_o));
endmodule

bind jtu_branch_unit jtu_chk #(
  .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .JUMP_BITS(JUMP_BITS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .iter_start_i (iter_start_i),
  .br_valid_i   (br_valid_i),
  .br_idx_i     (br_idx_i),
  .br_pos_i     (br_pos_i),
  .res_valid_o  (res_valid_o),
  .res_val_o    (res_val_o),
  .res_taken_o  (res_taken_o),
  .res_target_o (res_target_o)
);

// File: tb/jtu_branch_unit_tb.sv
module jtu_branch_unit_tb;
  localparam int NR = 8;
  localparam int IW = 8;
  localparam int JB = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          iter_start_i = 1'b0;
  logic          wr_valid_i = 1'b0;
  logic [2:0]    wr_reg_i = '0;
  logic [IW-1:0] wr_idx_i = '0;
  logic          br_valid_i = 1'b0;
  logic [IW-1:0] br_idx_i = '0;
  logic [2:0]    br_reg_i = '0;
  logic [63:0]   br_val_i = '0;
  logic [31:0]   br_imm_i = '0;
  logic [5:0]    br_pos_i = '0;
  logic          res_valid_o;
  logic [63:0]   res_val_o;
  logic          res_taken_o;
  logic [IW-1:0] res_target_o;

  jtu_branch_unit #(.NUM_REGS(NR), .IDX_W(IW), .JUMP_BITS(JB)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit          m_seen [NR];
  int          m_idx  [NR];
  logic [63:0] e_val = '0;
  bit          e_taken = 1'b0;
  int          e_tgt = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit ist, bit wv, int wr, int wi,
                     bit bv, int bi, int br, logic [63:0] val, logic [31:0] imm, int pos);
    logic [63:0] c, s;
    int b;
    bit tk;
    iter_start_i = ist; wr_valid_i = wv; wr_reg_i = 3'(wr); wr_idx_i = IW'(wi);
    br_valid_i = bv; br_idx_i = IW'(bi); br_reg_i = 3'(br); br_val_i = val;
    br_imm_i = imm; br_pos_i = 6'(pos);
    if (bv) begin
      b = (pos > 64 - JB) ? 64 - JB : pos;
      c = {{32{imm[31]}}, imm};
      c[b] = 1'b1;
      if (b > 0) c[b-1] = 1'b0;
      s = val + c;
      tk = 1'b1;
      for (int i = b; i < b + JB; i++) if (s[i]) tk = 1'b0;
      e_val = s; e_taken = tk;
      e_tgt = (!ist && m_seen[br]) ? (m_idx[br] + 1) % (1 << IW) : 0;
    end
    @(posedge clk_i);
    for (int r = 0; r < NR; r++) begin
      if (ist) m_seen[r] = 1'b0;
      if (wv && r == wr) begin m_seen[r] = 1'b1; m_idx[r] = wi; end
      if (bv) begin m_seen[r] = 1'b1; m_idx[r] = bi; end
    end
    @(negedge clk_i);
    chk(tag, "valid", 64'(res_valid_o), 64'(bv));
    chk(tag, "value", res_val_o, e_val);
    chk(tag, "taken", 64'(res_taken_o), 64'(e_taken));
    chk(tag, "target", 64'(res_target_o), 64'(e_tgt));
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 64'h0, 32'h0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin m_seen[r] = 1'b0; m_idx[r] = 0; end
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", "valid", 64'(res_valid_o), 64'h0);
    chk("R10", "value", res_val_o, 64'h0);
    chk("R10", "taken", 64'(res_taken_o), 64'h0);
    chk("R10", "target", 64'(res_target_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R6 untouched register: sum 16, not taken, target 0
    cyc("R6", 0, 0, 0, 0, 1, 5, 2, 64'h0, 32'h0, 4);
    chk("R6", "target", 64'(res_target_o), 64'h0);
    // R1 bit b-1 cleared, bit b set: imm 8, b 4 -> 16
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 64'h0, 32'h0, 0);
    cyc("R1", 0, 0, 0, 0, 1, 6, 1, 64'h0, 32'h8, 4);
    chk("R1", "value", res_val_o, 64'h10);
    // R8 write notify then branch -> idx+1
    cyc("R8", 0, 1, 3, 10, 0, 0, 0, 64'h0, 32'h0, 0);
    cyc("R4", 0, 0, 0, 0, 1, 12, 3, 64'h1234, 32'h7fff, 20);
    chk("R4", "target", 64'(res_target_o), 64'd11);
    // R7 all registers now point to 12
    cyc("R7", 0, 0, 0, 0, 1, 20, 5, 64'h5, 32'h1, 9);
    chk("R7", "target", 64'(res_target_o), 64'd13);
    // R3 taken: 256 + (-256) = 0 at b 8
    cyc("R3", 0, 0, 0, 0, 1, 21, 0, 64'h100, 32'hffffff00, 8);
    chk("R3", "taken", 64'(res_taken_o), 64'h1);
    chk("R3", "value", res_val_o, 64'h0);
    // R9 clamp 63 -> 56 and b 0
    cyc("R9", 0, 0, 0, 0, 1, 22, 4, 64'h0, 32'h0, 63);
    chk("R9", "value", res_val_o, 64'h0100_0000_0000_0000);
    cyc("R9", 0, 0, 0, 0, 1, 23, 4, 64'hffff_ffff_ffff_fffe, 32'h0, 0);
    chk("R9", "taken", 64'(res_taken_o), 64'h0);
    // R5 clear with branch in the same cycle
    cyc("R5", 1, 0, 0, 0, 1, 30, 6, 64'h77, 32'h3, 2);
    chk("R5", "target", 64'(res_target_o), 64'h0);
    cyc("R5", 1, 0, 0, 0, 0, 0, 0, 64'h0, 32'h0, 0);
    cyc("R5", 0, 0, 0, 0, 1, 31, 6, 64'h77, 32'h3, 2);
    // R8 write and branch same cycle: lookup ignores write, branch wins
    cyc("R8", 0, 1, 6, 40, 1, 41, 6, 64'h9, 32'h0, 3);
    chk("R8", "target", 64'(res_target_o), 64'd32);
    cyc("R8", 0, 0, 0, 0, 1, 42, 6, 64'h9, 32'h0, 3);
    chk("R8", "target", 64'(res_target_o), 64'd42);
    // R4 index wrap
    cyc("R4", 0, 0, 0, 0, 1, 255, 1, 64'h0, 32'h0, 1);
    cyc("R4", 0, 0, 0, 0, 1, 3, 1, 64'h0, 32'h0, 1);
    chk("R4", "target", 64'(res_target_o), 64'h0);
    // R10 hold while idle
    idle("R10"); idle("R10");
    // R2 random traffic
    for (int k = 0; k < 400; k++)
      cyc("R2", ($urandom_range(0, 15) == 0), $urandom_range(0, 1), $urandom_range(0, 7),
          $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 255),
          $urandom_range(0, 7), {$urandom(), $urandom()},
          ($urandom_range(0, 1) ? 32'h0 : $urandom()), $urandom_range(0, 63));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule